// File: doc/BRIEF.md
# Address-Collision Busy Arbiter

This block sits beside a two-port memory and watches both ports' enables and addresses. A collision exists when both ports are enabled on the same address in the same cycle. On a collision the block drives an active-low busy flag to the port that reached that address later, and it removes that port's write enable. The port that got there first keeps full access, and it is never told that anything happened. Writes from the busy side are dropped without any further signal.

Arrival is measured in clock cycles. A port arrives in the cycle in which its enable goes low, or in which its address changes while its enable is already low. When both ports arrive in the same cycle, the right port loses. The right port also loses when neither port arrives in the collision cycle, which can happen just after leaving slave mode. Once a grant is made it stays fixed for as long as the collision lasts. In slave mode the block does no arbitration of its own. It drives both busy outputs high and gates each port's writes with an externally supplied busy input, so that several blocks can share one decision.

Top module: `collision_arbiter`

## Requirements
- R1: When either enable (active low) is high, or the two addresses differ, both busy outputs are high.
- R2: The two busy outputs are never low in the same cycle.
- R3: In master mode, on a collision the port that arrived later sees its busy output low in that same cycle, and the other port's busy stays high. A port arrives when its enable goes low or its address changes while it is enabled.
- R4: If both ports arrive in the collision's first cycle, or neither does, the right port gets busy.
- R5: A busy grant is held unchanged for as long as the collision continues, whatever the write requests do.
- R6: A port's write enable equals its write request ANDed with its enable being low, and it is forced low while that port is blocked.
- R7: With slaveMode high, both busy outputs are high and a low busy input blocks writes on its own port.
- R8: With slaveMode low, the busy inputs have no effect on any output.
- R9: While reset is low both busy outputs are high. After reset no arrival history remains, so a collision present on release is treated as a same-cycle tie.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| slaveMode | input | 1 | 1: use the external busy inputs; 0: arbitrate internally |
| ceLeftN | input | 1 | Left port enable, active low |
| ceRightN | input | 1 | Right port enable, active low |
| addrLeft | input | ADDR_W | Left port address |
| addrRight | input | ADDR_W | Right port address |
| wrReqLeft | input | 1 | Left port write request |
| wrReqRight | input | 1 | Right port write request |
| busyInLeftN | input | 1 | External busy for the left port (slave mode), active low |
| busyInRightN | input | 1 | External busy for the right port (slave mode), active low |
| busyLeftN | output | 1 | Busy flag to the left port, active low |
| busyRightN | output | 1 | Busy flag to the right port, active low |
| wrEnLeft | output | 1 | Gated write enable for the left port |
| wrEnRight | output | 1 | Gated write enable for the right port |

## Verification
If the arrival history holds a stale value, the wrong side is flagged busy. This appears at the busy and write-enable outputs in the very cycle the collision begins, because those outputs are combinational on the stored history. If the grant register holds a stale value, the flag moves or drops during a collision that continues. This shows one cycle after the bad update. The stimulus therefore reopens collisions from each side, from a tie, and after a return from slave mode, and it checks every cycle of a held collision.

// File: rtl/collision_arb_pkg.sv
package collision_arb_pkg;

  // Comparison status from the datapath to the control.
  typedef struct packed {
    logic match;
    logic freshLeft;
    logic freshRight;
  } cmpStat_t;

  // Busy strobes from the control to the datapath (active high internally).
  typedef struct packed {
    logic busyLeft;
    logic busyRight;
  } busyStrobe_t;

  typedef enum logic [1:0] {
    GRANT_NONE       = 2'd0,
    GRANT_LEFT_BUSY  = 2'd1,
    GRANT_RIGHT_BUSY = 2'd2
  } grant_e;

endpackage

// File: rtl/collision_arb_dp.sv
module collision_arb_dp
  import collision_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              ceLeftN,
  input  logic              ceRightN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic [ADDR_W-1:0] addrRight,
  input  logic              wrReqLeft,
  input  logic              wrReqRight,
  input  logic              busyInLeftN,
  input  logic              busyInRightN,
  input  busyStrobe_t       strobe,
  output cmpStat_t          stat,
  output logic              busyLeftN,
  output logic              busyRightN,
  output logic              wrEnLeft,
  output logic              wrEnRight
);

  localparam int NUM_PORTS = 2;

  logic [NUM_PORTS-1:0] ceN;
  logic [NUM_PORTS-1:0] wrReq;
  logic [NUM_PORTS-1:0] busyInN;
  logic [NUM_PORTS-1:0] busyInt;
  logic [NUM_PORTS-1:0] fresh;
  logic [NUM_PORTS-1:0] blocked;
  logic [NUM_PORTS-1:0] wrEn;
  logic [NUM_PORTS-1:0] busyOutN;
  logic [ADDR_W-1:0]    addr [NUM_PORTS];

  assign ceN     = {ceRightN, ceLeftN};
  assign wrReq   = {wrReqRight, wrReqLeft};
  assign busyInN = {busyInRightN, busyInLeftN};
  assign busyInt = {strobe.busyRight, strobe.busyLeft};
  assign addr[0] = addrLeft;
  assign addr[1] = addrRight;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    logic              prevCeN;
    logic [ADDR_W-1:0] prevAddr;

    // Previous-cycle enable and address: the arrival history of this port.
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        prevCeN  <= 1'b1;
        prevAddr <= '0;
      end else begin
        prevCeN  <= ceN[p];
        prevAddr <= addr[p];
      end
    end

    assign fresh[p]    = !ceN[p] && (prevCeN || (prevAddr != addr[p]));
    assign blocked[p]  = slaveMode ? !busyInN[p] : busyInt[p];
    assign wrEn[p]     = wrReq[p] && !ceN[p] && !blocked[p];
    assign busyOutN[p] = slaveMode || !busyInt[p];
  end

  assign stat.match      = !ceN[0] && !ceN[1] && (addr[0] == addr[1]);
  assign stat.freshLeft  = fresh[0];
  assign stat.freshRight = fresh[1];

  assign busyLeftN  = busyOutN[0];
  assign busyRightN = busyOutN[1];
  assign wrEnLeft   = wrEn[0];
  assign wrEnRight  = wrEn[1];

endmodule

// File: rtl/collision_arb_ctl.sv
module collision_arb_ctl
  import collision_arb_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        slaveMode,
  input  cmpStat_t    stat,
  output busyStrobe_t strobe
);

  grant_e grantQ;
  grant_e decision;
  grant_e active;

  // A single late arrival on the left flags the left port; every other
  // case (right late, tie, or no arrival) flags the right port.
  always_comb begin
    if (stat.freshLeft && !stat.freshRight) decision = GRANT_LEFT_BUSY;
    else                                    decision = GRANT_RIGHT_BUSY;
  end

  always_comb begin
    if (stat.match && !slaveMode)
      active = (grantQ == GRANT_NONE) ? decision : grantQ;
    else
      active = GRANT_NONE;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) grantQ <= GRANT_NONE;
    else       grantQ <= active;
  end

  assign strobe.busyLeft  = rstN && (active == GRANT_LEFT_BUSY);
  assign strobe.busyRight = rstN && (active == GRANT_RIGHT_BUSY);

endmodule

// File: rtl/collision_arbiter.sv
module collision_arbiter
  import collision_arb_pkg::*;
#(
  parameter int ADDR_W = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              slaveMode,
  input  logic              ceLeftN,
  input  logic              ceRightN,
  input  logic [ADDR_W-1:0] addrLeft,
  input  logic [ADDR_W-1:0] addrRight,
  input  logic              wrReqLeft,
  input  logic              wrReqRight,
  input  logic              busyInLeftN,
  input  logic              busyInRightN,
  output logic              busyLeftN,
  output logic              busyRightN,
  output logic              wrEnLeft,
  output logic              wrEnRight
);

  cmpStat_t    stat;
  busyStrobe_t strobe;

  collision_arb_dp #(.ADDR_W(ADDR_W)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .slaveMode    (slaveMode),
    .ceLeftN      (ceLeftN),
    .ceRightN     (ceRightN),
    .addrLeft     (addrLeft),
    .addrRight    (addrRight),
    .wrReqLeft    (wrReqLeft),
    .wrReqRight   (wrReqRight),
    .busyInLeftN  (busyInLeftN),
    .busyInRightN (busyInRightN),
    .strobe       (strobe),
    .stat         (stat),
    .busyLeftN    (busyLeftN),
    .busyRightN   (busyRightN),
    .wrEnLeft     (wrEnLeft),
    .wrEnRight    (wrEnRight)
  );

  collision_arb_ctl ctl_i (
    .clk       (clk),
    .rstN      (rstN),
    .slaveMode (slaveMode),
    .stat      (stat),
    .strobe    (strobe)
  );

endmodule

// File: rtl/collision_arb_chk.sv
module collision_arb_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rstN,
  input logic              slaveMode,
  input logic              ceLeftN,
  input logic              ceRightN,
  input logic [ADDR_W-1:0] addrLeft,
  input logic [ADDR_W-1:0] addrRight,
  input logic              busyInLeftN,
  input logic              busyInRightN,
  input logic              busyLeftN,
  input logic              busyRightN,
  input logic              wrEnLeft,
  input logic              wrEnRight
);

  logic matchNow;
  assign matchNow = !ceLeftN && !ceRightN && (addrLeft == addrRight);

  p_free_r1: assert property (@(posedge clk) disable iff (!rstN)
    !matchNow |-> (busyLeftN && busyRightN));

  p_mutex_r2: assert property (@(posedge clk) disable iff (!rstN)
    !(!busyLeftN && !busyRightN));

  p_hold_left_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && matchNow && !busyLeftN) ##1 (!slaveMode && matchNow) |-> !busyLeftN);

  p_hold_right_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && matchNow && !busyRightN) ##1 (!slaveMode && matchNow) |-> !busyRightN);

  p_gate_left_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busyLeftN |-> !wrEnLeft);

  p_gate_right_r6: assert property (@(posedge clk) disable iff (!rstN)
    !busyRightN |-> !wrEnRight);

  p_slave_high_r7: assert property (@(posedge clk) disable iff (!rstN)
    slaveMode |-> (busyLeftN && busyRightN));

  p_slave_block_r7: assert property (@(posedge clk) disable iff (!rstN)
    (slaveMode && (!busyInLeftN || !busyInRightN)) |->
      ((busyInLeftN || !wrEnLeft) && (busyInRightN || !wrEnRight)));

  p_master_collision_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!slaveMode && matchNow) |-> (busyLeftN != busyRightN));

endmodule

bind collision_arbiter collision_arb_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .slaveMode    (slaveMode),
  .ceLeftN      (ceLeftN),
  .ceRightN     (ceRightN),
  .addrLeft     (addrLeft),
  .addrRight    (addrRight),
  .busyInLeftN  (busyInLeftN),
  .busyInRightN (busyInRightN),
  .busyLeftN    (busyLeftN),
  .busyRightN   (busyRightN),
  .wrEnLeft     (wrEnLeft),
  .wrEnRight    (wrEnRight)
);

// File: tb/collision_arbiter_tb.sv
`timescale 1ns/1ps
module collision_arbiter_tb_top;

  localparam int ADDR_W = 10;

  typedef struct packed {
    logic        slv;
    logic        ceL;
    logic        ceR;
    logic [9:0]  aL;
    logic [9:0]  aR;
    logic        wL;
    logic        wR;
    logic        biL;
    logic        biR;
    logic        eBL;
    logic        eBR;
    logic        eWL;
    logic        eWR;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b1,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // R1 both off
    '{1'b0,1'b0,1'b1,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b0, 4'd1}, // R1 one on
    '{1'b0,1'b0,1'b0,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd3}, // R3 right late
    '{1'b0,1'b0,1'b0,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd5}, // R5 held
    '{1'b0,1'b0,1'b0,10'd5,   10'd5,   1'b0,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b0,1'b0, 4'd5}, // R5 winner drops write
    '{1'b0,1'b0,1'b0,10'd5,   10'd6,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1 differ
    '{1'b0,1'b0,1'b0,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd6}, // R6 right moved in
    '{1'b0,1'b1,1'b1,10'd5,   10'd5,   1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b0,1'b0, 4'd1}, // R1 release
    '{1'b0,1'b0,1'b0,10'd1023,10'd1023,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd4}, // R4 tie
    '{1'b0,1'b0,1'b0,10'd256, 10'd1023,1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd1}, // R1
    '{1'b0,1'b0,1'b0,10'd1023,10'd1023,1'b1,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0,1'b1, 4'd3}, // R3 left late
    '{1'b0,1'b0,1'b0,10'd1023,10'd1023,1'b1,1'b1,1'b0,1'b0, 1'b0,1'b1,1'b0,1'b1, 4'd8}, // R8 inputs ignored
    '{1'b0,1'b0,1'b0,10'd1,   10'd2,   1'b1,1'b1,1'b0,1'b0, 1'b1,1'b1,1'b1,1'b1, 4'd8}, // R8
    '{1'b1,1'b0,1'b0,10'd32,  10'd32,  1'b1,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1,1'b1, 4'd7}, // R7 slave free
    '{1'b1,1'b0,1'b0,10'd32,  10'd32,  1'b1,1'b1,1'b0,1'b1, 1'b1,1'b1,1'b0,1'b1, 4'd7}, // R7 left blocked
    '{1'b1,1'b0,1'b0,10'd32,  10'd32,  1'b1,1'b1,1'b1,1'b0, 1'b1,1'b1,1'b1,1'b0, 4'd7}, // R7 right blocked
    '{1'b0,1'b0,1'b0,10'd32,  10'd32,  1'b1,1'b1,1'b1,1'b1, 1'b1,1'b0,1'b1,1'b0, 4'd4}  // R4 no arrival
  };

  logic              clk = 1'b0;
  logic              rstN;
  logic              slaveMode;
  logic              ceLeftN, ceRightN;
  logic [ADDR_W-1:0] addrLeft, addrRight;
  logic              wrReqLeft, wrReqRight;
  logic              busyInLeftN, busyInRightN;
  logic              busyLeftN, busyRightN, wrEnLeft, wrEnRight;

  int compared = 0;
  int mismatched = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  collision_arbiter #(.ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .slaveMode(slaveMode),
    .ceLeftN(ceLeftN), .ceRightN(ceRightN),
    .addrLeft(addrLeft), .addrRight(addrRight),
    .wrReqLeft(wrReqLeft), .wrReqRight(wrReqRight),
    .busyInLeftN(busyInLeftN), .busyInRightN(busyInRightN),
    .busyLeftN(busyLeftN), .busyRightN(busyRightN),
    .wrEnLeft(wrEnLeft), .wrEnRight(wrEnRight)
  );

  task automatic check(input string what, input int req, input logic [3:0] act, input logic [3:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL R%0d %s: actual busyL/busyR/wrL/wrR=%b expected=%b", req, what, act, exp);
    end
  endtask

  function automatic logic [3:0] outs();
    return {busyLeftN, busyRightN, wrEnLeft, wrEnRight};
  endfunction

  task automatic drive(input vec_t v);
    slaveMode = v.slv; ceLeftN = v.ceL; ceRightN = v.ceR;
    addrLeft = v.aL; addrRight = v.aR;
    wrReqLeft = v.wL; wrReqRight = v.wR;
    busyInLeftN = v.biL; busyInRightN = v.biR;
  endtask

  initial begin
    rstN = 1'b0;
    drive(VEC[0]);
    #1;
    check("reset state", 9, outs(), 4'b1100); // R9
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      drive(VEC[i]);
      #1;
      check($sformatf("vector %0d", i), int'(VEC[i].req),
            outs(), {VEC[i].eBL, VEC[i].eBR, VEC[i].eWL, VEC[i].eWR});
      check($sformatf("vector %0d exclusive", i), 2, // R2
            {2'b00, !busyLeftN && !busyRightN, 1'b0}, 4'b0000);
    end

    // R9: reset in the middle of a held left-busy grant
    @(negedge clk);
    drive(VEC[9]);
    @(negedge clk);
    drive(VEC[10]);
    #1;
    check("left grant before reset", 3, outs(), 4'b0101);
    @(negedge clk);
    rstN = 1'b0;
    #1;
    check("busy released in reset", 9, {busyLeftN, busyRightN, 2'b00}, 4'b1100);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check("history cleared, tie after reset", 9, outs(), 4'b1010);
    @(negedge clk);
    #1;
    check("grant held after reset", 5, outs(), 4'b1010);

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

endmodule